// File: doc/BRIEF.md
# Configuration I/O Window Decoder

This block is the configuration register slice of one device function. It does two jobs. It holds an I/O base register that software programs to place an 8-byte window anywhere in a 16-bit I/O space. It also holds a 16-bit subsystem vendor identifier that can be written only once after reset. Configuration software reaches both registers through a dword-addressed read/write port with byte enables.

In parallel, the block watches processor I/O cycles and raises a claim in the same cycle when the cycle falls inside the programmed window. A claim is given only when the function is allowed to respond: it must be powered up in its fully active state, its I/O decoding must be enabled, it must be switched on, and it must not be disabled by fuse.

Top module: `iowin_cfg_top`

## Requirements
- R1: After reset, a read of dword offset 08h returns 0000_0001h, and a read of dword offset 0Bh returns 0000_0000h with the write lock clear.
- R2: Bits 31:16 of dword 08h always read as zero, and writes to them have no effect.
- R3: Bits 15:3 of dword 08h are writable. Byte enable 0 controls bits 7:3 and byte enable 1 controls bits 15:8, and a byte left disabled keeps its value.
- R4: Bits 2:0 of dword 08h always read as 001b, whatever is written.
- R5: `io_claim` is low unless `pwr_state` is 00b (full power), `io_space_en` is 1, `dev_on` is 1 and `fuse_dis` is 0. The other codes 01b, 10b and 11b are the lower power states.
- R6: While R5 allows access, `io_claim` is high in the same cycle as `io_req` exactly when `io_addr[15:3]` equals the programmed bits 15:3 and `io_size` is 00b (8-bit), 01b (16-bit) or 10b (32-bit). Code 11b is never claimed.
- R7: The identifier sits at dword 0Bh, bits 15:0, and bits 31:16 of that dword read as zero. The first write with byte enable 0 or 1 set stores the enabled bytes and locks the register. A write that enables only bytes 2 and 3 does not lock it. Once locked, every later write is ignored.
- R8: `cfg_rdata` carries the addressed register one clock after a cycle with `cfg_rd_en` high. It is zero after any cycle without a read and for offsets other than 08h and 0Bh. Writes to other offsets change nothing.
- R9: Reset clears the lock, so that the identifier can be written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_dw_off | input | 6 | Configuration dword offset |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| io_space_en | input | 1 | I/O decode enable from the command register |
| pwr_state | input | 2 | Power state, 00b full power |
| dev_on | input | 1 | Function switched on |
| fuse_dis | input | 1 | Disabled by fuse or fuse override |
| io_req | input | 1 | Processor I/O cycle present |
| io_addr | input | 16 | I/O cycle address |
| io_size | input | 2 | Access size: 00b 8-bit, 01b 16-bit, 10b 32-bit |
| io_claim | output | 1 | Window claims the current I/O cycle |

## Verification
The claim is combinational, so the bench checks `io_claim` a moment after it drives an I/O request, before the next rising edge. Read data passes through one register, so the bench captures the expected value at the rising edge that samples the read strobe and compares it at the following falling edge. The bench's behavioural model applies register writes at that same edge, so a read issued in the same cycle as a write sees the old contents. Every bench cycle performs both comparisons, and the expected values come from the model.

// File: rtl/iowin_cfg_pkg.sv
// Shared constants and encodings for the configuration I/O window block.
// Assumes dword-addressed configuration space of 64 dwords.
package iowin_cfg_pkg;
    localparam int CFG_OFF_W = 6;
    localparam logic [CFG_OFF_W-1:0] DW_IOWIN = 6'h08;
    localparam logic [CFG_OFF_W-1:0] DW_SUBID = 6'h0B;

    typedef enum logic [1:0] {
        PS_FULL  = 2'b00,
        PS_LOW1  = 2'b01,
        PS_LOW2  = 2'b10,
        PS_LOW3  = 2'b11
    } pwr_state_e;

    typedef enum logic [1:0] {
        IOSZ_BYTE = 2'b00,
        IOSZ_WORD = 2'b01,
        IOSZ_DWORD = 2'b10,
        IOSZ_RSVD = 2'b11
    } io_size_e;
endpackage

// File: rtl/iowin_base_reg.sv
// I/O window base register: stores address bits ADDR_W-1:WIN_BITS with
// per-byte write enables; the read value shows zero above ADDR_W, zeros in
// the low window bits and a one in bit 0 marking I/O space.
// Assumes ADDR_W <= 32 and WIN_BITS >= 1.
module iowin_base_reg #(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_sel,
    input  logic [3:0]                 be,
    input  logic [31:0]                wdata,
    output logic [ADDR_W-1:WIN_BITS]   base_q,
    output logic [31:0]                rd_val
);
    localparam int PAD_HI = 32 - ADDR_W;

    // Byte-masked update of the programmable base bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_sel) begin
            for (int i = WIN_BITS; i < ADDR_W; i++) begin
                if (be[i/8]) base_q[i] <= wdata[i];
            end
        end
    end

    // Presentation of the register as a full dword.
    always_comb begin
        rd_val = {{PAD_HI{1'b0}}, base_q, {(WIN_BITS-1){1'b0}}, 1'b1};
    end

    // Base keeps its value in every cycle without a write (R3).
    p_base_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(base_q));
endmodule

// File: rtl/iowin_subid_reg.sv
// Write-once identifier register. The first write enabling any of its bytes
// stores those bytes and locks; only reset unlocks. Assumes ID_W is a
// multiple of 8 and at most 32.
module iowin_subid_reg #(
    parameter int ID_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_sel,
    input  logic [3:0]      be,
    input  logic [31:0]     wdata,
    output logic [ID_W-1:0] id_q,
    output logic            locked_q,
    output logic [31:0]     rd_val
);
    localparam int NBYTES = ID_W / 8;

    logic touch;

    // A write counts only if it enables a byte of this register.
    always_comb begin
        touch = wr_sel && (|be[NBYTES-1:0]);
    end

    // Store enabled bytes on the first touching write, then lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q     <= '0;
            locked_q <= 1'b0;
        end else if (touch && !locked_q) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (be[b]) id_q[b*8 +: 8] <= wdata[b*8 +: 8];
            end
            locked_q <= 1'b1;
        end
    end

    // Dword view with zero above the identifier.
    always_comb begin
        rd_val = 32'(id_q);
    end

    // Lock is sticky until reset (R7).
    p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> locked_q);
    // Locked value never changes (R7).
    p_locked_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable(id_q));
endmodule

// File: rtl/iowin_claim.sv
// Combinational claim of processor I/O cycles against the programmed window.
// Assumes the window spans 2**WIN_BITS bytes aligned to its size.
module iowin_claim
    import iowin_cfg_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 3
) (
    input  logic [ADDR_W-1:WIN_BITS] base,
    input  logic                     io_req,
    input  logic [ADDR_W-1:0]        io_addr,
    input  logic [1:0]               io_size,
    input  logic                     io_space_en,
    input  logic [1:0]               pwr_state,
    input  logic                     dev_on,
    input  logic                     fuse_dis,
    output logic                     claim
);
    logic access_ok;
    logic size_ok;
    logic hit;

    // Gate, size legality and window match combined into the claim.
    always_comb begin
        access_ok = (pwr_state == PS_FULL) && io_space_en && dev_on && !fuse_dis;
        size_ok   = (io_size != IOSZ_RSVD);
        hit       = (io_addr[ADDR_W-1:WIN_BITS] == base);
        claim     = io_req && access_ok && size_ok && hit;
    end
endmodule

// File: rtl/iowin_cfg_top.sv
// Configuration slice with an I/O window base register, a write-once
// identifier and a same-cycle I/O claim. Reads are registered (one clock).
// Assumes single-cycle configuration strobes.
module iowin_cfg_top
    import iowin_cfg_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 3,
    parameter int ID_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic                 cfg_rd_en,
    input  logic [CFG_OFF_W-1:0] cfg_dw_off,
    input  logic [3:0]           cfg_be,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic                 io_space_en,
    input  logic [1:0]           pwr_state,
    input  logic                 dev_on,
    input  logic                 fuse_dis,
    input  logic                 io_req,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic [1:0]           io_size,
    output logic                 io_claim
);
    logic                     wr_win;
    logic                     wr_id;
    logic [ADDR_W-1:WIN_BITS] base_q;
    logic [31:0]              win_rd;
    logic [ID_W-1:0]          id_q;
    logic                     id_locked;
    logic [31:0]              id_rd;

    // Offset decode for writes.
    always_comb begin
        wr_win = cfg_wr_en && (cfg_dw_off == DW_IOWIN);
        wr_id  = cfg_wr_en && (cfg_dw_off == DW_SUBID);
    end

    iowin_base_reg #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_base (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_win), .be(cfg_be),
        .wdata(cfg_wdata), .base_q(base_q), .rd_val(win_rd)
    );

    iowin_subid_reg #(.ID_W(ID_W)) u_subid (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_id), .be(cfg_be),
        .wdata(cfg_wdata), .id_q(id_q), .locked_q(id_locked), .rd_val(id_rd)
    );

    iowin_claim #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_claim (
        .base(base_q), .io_req(io_req), .io_addr(io_addr), .io_size(io_size),
        .io_space_en(io_space_en), .pwr_state(pwr_state), .dev_on(dev_on),
        .fuse_dis(fuse_dis), .claim(io_claim)
    );

    // Registered read mux; zero when idle or for unmapped offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rdata <= '0;
        end else if (cfg_rd_en) begin
            case (cfg_dw_off)
                DW_IOWIN: cfg_rdata <= win_rd;
                DW_SUBID: cfg_rdata <= id_rd;
                default:  cfg_rdata <= '0;
            endcase
        end else begin
            cfg_rdata <= '0;
        end
    end

    // No claim outside the permitted access conditions (R5).
    p_claim_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        io_claim |-> (pwr_state == PS_FULL && io_space_en && dev_on && !fuse_dis));
    // A claim always lies inside the stored window (R6).
    p_claim_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        io_claim |-> (io_req && io_addr[ADDR_W-1:WIN_BITS] == base_q));
    // Read data is zero after a cycle without a read (R8).
    p_rdata_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd_en |=> (cfg_rdata == 32'h0));
endmodule

// File: tb/iowin_cfg_top_tb.sv
module iowin_cfg_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
    logic [5:0]  cfg_dw_off = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        io_space_en = 1'b1;
    logic [1:0]  pwr_state = 2'b00;
    logic        dev_on = 1'b1, fuse_dis = 1'b0;
    logic        io_req = 1'b0;
    logic [15:0] io_addr = '0;
    logic [1:0]  io_size = '0;
    logic        io_claim;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    logic [15:0] m_base = 16'h0;
    logic [15:0] m_id = 16'h0;
    bit          m_lock = 0;
    logic [31:0] m_rd = 32'h0;

    always #2 clk = ~clk;

    iowin_cfg_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
        .cfg_dw_off(cfg_dw_off), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .io_space_en(io_space_en), .pwr_state(pwr_state),
        .dev_on(dev_on), .fuse_dis(fuse_dis), .io_req(io_req), .io_addr(io_addr),
        .io_size(io_size), .io_claim(io_claim)
    );

    function automatic logic [31:0] model_read(input logic [5:0] off);
        if (off == 6'h08) return {16'h0, m_base[15:3], 3'b001};
        if (off == 6'h0B) return {16'h0, m_id};
        return 32'h0;
    endfunction

    function automatic bit model_claim();
        bit allowed = (pwr_state == 2'b00) && io_space_en && dev_on && !fuse_dis;
        return io_req && allowed && (io_size != 2'b11) && (io_addr[15:3] == m_base[15:3]);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: claim checked before the edge, read data after it
    task automatic cyc(input string tag);
        #1;
        check({tag, " claim"}, 32'(io_claim), 32'(model_claim()));
        @(posedge clk);
        m_rd = cfg_rd_en ? model_read(cfg_dw_off) : 32'h0;
        if (!rst_n) begin
            m_base = 16'h0; m_id = 16'h0; m_lock = 0; m_rd = 32'h0;
        end else if (cfg_wr_en) begin
            if (cfg_dw_off == 6'h08) begin
                if (cfg_be[0]) m_base[7:0]  = cfg_wdata[7:0];
                if (cfg_be[1]) m_base[15:8] = cfg_wdata[15:8];
                m_base[2:0] = 3'b000;
            end else if (cfg_dw_off == 6'h0B && !m_lock && (cfg_be[0] || cfg_be[1])) begin
                if (cfg_be[0]) m_id[7:0]  = cfg_wdata[7:0];
                if (cfg_be[1]) m_id[15:8] = cfg_wdata[15:8];
                m_lock = 1;
            end
        end
        @(negedge clk);
        check({tag, " rdata"}, cfg_rdata, m_rd);
    endtask

    task automatic quiet();
        cfg_wr_en = 0; cfg_rd_en = 0; io_req = 0; cfg_be = '0; cfg_wdata = '0;
    endtask

    task automatic cfg_wr(input logic [5:0] off, input logic [3:0] be,
                          input logic [31:0] d, input string tag);
        quiet(); cfg_wr_en = 1; cfg_dw_off = off; cfg_be = be; cfg_wdata = d;
        cyc(tag);
    endtask

    task automatic cfg_rd(input logic [5:0] off, input string tag);
        quiet(); cfg_rd_en = 1; cfg_dw_off = off;
        cyc(tag);
        quiet(); cyc(tag);
    endtask

    task automatic io(input logic [15:0] a, input logic [1:0] sz, input string tag);
        quiet(); io_req = 1; io_addr = a; io_size = sz;
        cyc(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        quiet(); rst_n = 0;
        cyc("R1"); cyc("R1");
        rst_n = 1;
        cfg_rd(6'h08, "R1");
        cfg_rd(6'h0B, "R1");
        // reserved upper bits and fixed low bits
        cfg_wr(6'h08, 4'hF, 32'hFFFF_FFFF, "R2");
        cfg_rd(6'h08, "R2");
        cfg_wr(6'h08, 4'b0001, 32'h0000_0012, "R3");
        cfg_rd(6'h08, "R3");
        cfg_wr(6'h08, 4'b0010, 32'hABCD_1200, "R3");
        cfg_rd(6'h08, "R4");
        cfg_wr(6'h08, 4'b1100, 32'h0000_0000, "R2");
        cfg_rd(6'h08, "R2");
        // window at 0340h, low bits of the write dropped
        cfg_wr(6'h08, 4'b0011, 32'h0000_0347, "R4");
        cfg_rd(6'h08, "R4");
        io(16'h0340, 2'b00, "R6");
        io(16'h0343, 2'b01, "R6");
        io(16'h0347, 2'b10, "R6");
        io(16'h0348, 2'b00, "R6");
        io(16'h033F, 2'b00, "R6");
        io(16'h0344, 2'b11, "R6");
        io(16'h8340, 2'b00, "R6");
        quiet(); io_addr = 16'h0341; cyc("R6");
        // gating conditions
        for (int p = 1; p < 4; p++) begin
            pwr_state = 2'(p); io(16'h0342, 2'b01, "R5");
        end
        pwr_state = 2'b00;
        io_space_en = 0; io(16'h0342, 2'b00, "R5"); io_space_en = 1;
        dev_on = 0;      io(16'h0342, 2'b00, "R5"); dev_on = 1;
        fuse_dis = 1;    io(16'h0342, 2'b00, "R5"); fuse_dis = 0;
        io(16'h0342, 2'b00, "R5");
        // write-once identifier
        cfg_wr(6'h0B, 4'b1100, 32'hFFFF_FFFF, "R7");
        cfg_rd(6'h0B, "R7");
        cfg_wr(6'h0B, 4'b0001, 32'h1234_ABCD, "R7");
        cfg_rd(6'h0B, "R7");
        cfg_wr(6'h0B, 4'b0011, 32'hFFFF_FFFF, "R7");
        cfg_wr(6'h0B, 4'b0010, 32'h0000_5500, "R7");
        cfg_rd(6'h0B, "R7");
        // read in the same cycle as a write sees old data
        quiet(); cfg_wr_en = 1; cfg_rd_en = 1; cfg_dw_off = 6'h08;
        cfg_be = 4'b0011; cfg_wdata = 32'h0000_1000; cyc("R8");
        quiet(); cyc("R8");
        cfg_rd(6'h08, "R8");
        // unmapped offsets
        cfg_wr(6'h00, 4'hF, 32'hFFFF_FFFF, "R8");
        cfg_wr(6'h09, 4'hF, 32'hFFFF_FFFF, "R8");
        cfg_rd(6'h00, "R8");
        cfg_rd(6'h09, "R8");
        cfg_rd(6'h3F, "R8");
        cfg_rd(6'h08, "R8");
        cfg_rd(6'h0B, "R8");
        // reset clears the lock
        quiet(); rst_n = 0; cyc("R9"); rst_n = 1;
        cfg_rd(6'h0B, "R9");
        cfg_rd(6'h08, "R9");
        cfg_wr(6'h0B, 4'b0011, 32'h0000_BEEF, "R9");
        cfg_rd(6'h0B, "R9");
        cfg_wr(6'h0B, 4'b0011, 32'h0000_0000, "R9");
        cfg_rd(6'h0B, "R9");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule